// File: doc/BRIEF.md
# Receiver Detection Interval Timer

This block paces receiver-detection attempts on a downstream-facing port. It counts millisecond ticks and, once the interval chosen for the current link power state has run out, it raises a one-cycle detection request. While the link is disconnected the interval comes from a short table. While the link sits in U2/U3 it comes from a second, longer table. In every other link state the timer stays idle.

A completed warm reset normally triggers an immediate detection request. That request can be withheld when the far end had already started polling during the warm reset. Detection in U2/U3 can also be switched off entirely. A separate enable makes the block drop the termination at the start of a detection sequence. It does this by pulsing a termination-off control together with the request that opens the sequence.

Top module: `rxdet_pacer`

## Requirements
- R1: In the disconnected state (link_state = 1), requests come every 4, 6, 36 or 84 ms for norm_code 0, 1, 2 or 3.
- R2: In the U2/U3 state (link_state = 2), requests come every 48, 84, 120 or 156 ms for lp_code 0, 1, 2 or 3.
- R3: det_req is high for exactly one clock per request. Requests repeat at the same interval while the state and code stay fixed.
- R4: A change of link_state restarts the count. The first request in the new state comes one full interval after the change.
- R5: With link_state equal to 0 or 3, the timer issues no request.
- R6: With lp_det_off = 1, the timer issues no request while link_state = 2.
- R7: A pulse on warm_done produces a det_req in the next clock, unless R8 applies.
- R8: When warm_skip_en = 1 and far_polled = 1 during a warm_done pulse, no request follows that warm reset.
- R9: With term_drop_en = 1, the request caused by a warm reset has term_off high in the same clock. With term_drop_en = 0, term_off never rises.
- R10: With term_drop_en = 1, the first timed request after entering the disconnected state carries term_off high. Later requests in that state carry it low.
- R11: During and right after reset, det_req and term_off are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| link_state | input | 2 | 0 other, 1 disconnected, 2 U2/U3, 3 other |
| warm_done | input | 1 | One-cycle pulse when a warm reset completes |
| far_polled | input | 1 | Far end started polling during the warm reset |
| norm_code | input | 2 | Interval code for the disconnected state |
| lp_code | input | 2 | Interval code for U2/U3 |
| lp_det_off | input | 1 | Suppress detection in U2/U3 |
| warm_skip_en | input | 1 | Allow skipping detection after a polled warm reset |
| term_drop_en | input | 1 | Turn termination off at the start of detection |
| det_req | output | 1 | One-cycle detection request |
| term_off | output | 1 | Termination-off pulse aligned with det_req |

## Verification
The assertions assume that warm_done is a single-cycle pulse. They also assume it never arrives in the same cycle as a link_state change, and that ms_tick never arrives in two consecutive cycles. The stimulus respects all three. It drives ticks one cycle wide with idle cycles between them. It applies warm-reset pulses only while the link stays in a fixed state. After every state change it inserts an idle cycle before the next tick, so the restart of the count is seen cleanly.

// File: rtl/rxdet_pkg.sv
package rxdet_pkg;

    typedef enum logic [1:0] {
        LS_IDLE   = 2'd0,
        LS_DISC   = 2'd1,
        LS_LOWPWR = 2'd2,
        LS_SPARE  = 2'd3
    } link_st_e;

    localparam int unsigned MAX_INTERVAL_MS = 156;

    typedef struct packed {
        logic hit;
        logic warm_go;
        logic first;
    } req_cause_t;

    function automatic logic [7:0] disc_interval_ms(input logic [1:0] code);
        case (code)
            2'd0:    return 8'd4;
            2'd1:    return 8'd6;
            2'd2:    return 8'd36;
            default: return 8'd84;
        endcase
    endfunction

    function automatic logic [7:0] lowpwr_interval_ms(input logic [1:0] code);
        return 8'd48 + 8'(code) * 8'd36;
    endfunction

endpackage

// File: rtl/rxdet_interval_sel.sv
module rxdet_interval_sel
    import rxdet_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic [1:0]       norm_code,
    input  logic [1:0]       lp_code,
    input  logic             lowpwr_mode,
    output logic [CNT_W-1:0] limit
);
    logic [7:0] disc_ms;
    logic [7:0] lp_ms;

    always_comb begin
        disc_ms = disc_interval_ms(norm_code);
        lp_ms   = lowpwr_interval_ms(lp_code);
        limit   = lowpwr_mode ? CNT_W'(lp_ms) : CNT_W'(disc_ms);
    end
endmodule

// File: rtl/rxdet_ms_counter.sv
module rxdet_ms_counter
    import rxdet_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             hit
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_inc;

    always_comb begin
        cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);
        hit     = run && !clear && tick && (cnt_inc >= {1'b0, limit});
    end

    always_ff @(posedge clk) begin
        if (rst || !run || clear || hit) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_inc[CNT_W-1:0];
        end
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CNT_W'(MAX_INTERVAL_MS));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt_q == '0));
endmodule

// File: rtl/rxdet_req_gen.sv
module rxdet_req_gen
    import rxdet_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic state_chg,
    input  logic now_disc,
    input  logic warm_done,
    input  logic far_polled,
    input  logic warm_skip_en,
    input  logic term_drop_en,
    output logic det_req,
    output logic term_off
);
    req_cause_t cause;
    logic       first_q;
    logic       req_q;
    logic       term_q;

    always_comb begin
        cause.hit     = hit;
        cause.warm_go = warm_done && !(warm_skip_en && far_polled);
        cause.first   = first_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q <= 1'b0;
            req_q   <= 1'b0;
            term_q  <= 1'b0;
        end else begin
            if (state_chg) begin
                first_q <= now_disc;
            end else if (cause.hit) begin
                first_q <= 1'b0;
            end
            req_q  <= cause.hit || cause.warm_go;
            term_q <= term_drop_en && (cause.warm_go || (cause.hit && cause.first));
        end
    end

    assign det_req  = req_q;
    assign term_off = term_q;

    // R7
    warm_req_chk: assert property (@(posedge clk) disable iff (rst)
        (warm_done && !(warm_skip_en && far_polled)) |=> det_req);

    // R8
    warm_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (warm_done && warm_skip_en && far_polled && !hit) |=> !det_req);

    // R9
    term_with_req_chk: assert property (@(posedge clk) disable iff (rst)
        term_off |-> det_req);
endmodule

// File: rtl/rxdet_pacer.sv
module rxdet_pacer
    import rxdet_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ms_tick,
    input  logic [1:0] link_state,
    input  logic       warm_done,
    input  logic       far_polled,
    input  logic [1:0] norm_code,
    input  logic [1:0] lp_code,
    input  logic       lp_det_off,
    input  logic       warm_skip_en,
    input  logic       term_drop_en,
    output logic       det_req,
    output logic       term_off
);
    link_st_e         st_now;
    link_st_e         st_q;
    logic             state_chg;
    logic             active;
    logic             hit;
    logic [CNT_W-1:0] limit;

    always_comb begin
        st_now    = link_st_e'(link_state);
        state_chg = (st_now != st_q);
        active    = (st_now == LS_DISC) || ((st_now == LS_LOWPWR) && !lp_det_off);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= LS_IDLE;
        else     st_q <= st_now;
    end

    rxdet_interval_sel #(.CNT_W(CNT_W)) u_sel (
        .norm_code   (norm_code),
        .lp_code     (lp_code),
        .lowpwr_mode (st_now == LS_LOWPWR),
        .limit       (limit)
    );

    rxdet_ms_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .run   (active && !state_chg),
        .clear (warm_done),
        .tick  (ms_tick),
        .limit (limit),
        .hit   (hit)
    );

    rxdet_req_gen u_req (
        .clk          (clk),
        .rst          (rst),
        .hit          (hit),
        .state_chg    (state_chg),
        .now_disc     (st_now == LS_DISC),
        .warm_done    (warm_done),
        .far_polled   (far_polled),
        .warm_skip_en (warm_skip_en),
        .term_drop_en (term_drop_en),
        .det_req      (det_req),
        .term_off     (term_off)
    );

    // R5
    idle_state_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(link_state[0] == link_state[1]) && !$past(warm_done)) |-> !det_req);

    // R6
    lowpwr_off_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(link_state == 2'd2 && lp_det_off) && !$past(warm_done)) |-> !det_req);

    // R9
    term_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(term_drop_en) |-> !term_off);
endmodule

// File: tb/rxdet_pacer_bench.sv
module rxdet_pacer_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ms_tick = 1'b0;
    logic [1:0] link_state = 2'd0;
    logic       warm_done = 1'b0;
    logic       far_polled = 1'b0;
    logic [1:0] norm_code = 2'd1;
    logic [1:0] lp_code = 2'd0;
    logic       lp_det_off = 1'b0;
    logic       warm_skip_en = 1'b0;
    logic       term_drop_en = 1'b0;
    logic       det_req;
    logic       term_off;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rxdet_pacer u_rxdet_pacer (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .link_state(link_state),
        .warm_done(warm_done), .far_polled(far_polled), .norm_code(norm_code),
        .lp_code(lp_code), .lp_det_off(lp_det_off), .warm_skip_en(warm_skip_en),
        .term_drop_en(term_drop_en), .det_req(det_req), .term_off(term_off)
    );

    // {state, code, expected interval in ms}
    localparam logic [11:0] VEC [0:7] = '{
        {2'd1, 2'd0, 8'd4},   {2'd1, 2'd1, 8'd6},
        {2'd1, 2'd2, 8'd36},  {2'd1, 2'd3, 8'd84},
        {2'd2, 2'd0, 8'd48},  {2'd2, 2'd1, 8'd84},
        {2'd2, 2'd2, 8'd120}, {2'd2, 2'd3, 8'd156}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic tick(output logic rq, output logic tm);
        @(negedge clk) ms_tick = 1'b1;
        @(negedge clk) ms_tick = 1'b0;
        rq = det_req;
        tm = term_off;
    endtask

    // ticks until a request appears (0 = none within max_t); also checks pulse width
    task automatic measure(input int max_t, output int n, output logic tm_seen);
        logic rq, tm;
        n = 0;
        tm_seen = 1'b0;
        for (int k = 1; k <= max_t; k++) begin
            tick(rq, tm);
            if (rq) begin
                n = k;
                tm_seen = tm;
                @(negedge clk);
                check("R3 pulse width", int'(det_req), 0);
                break;
            end
        end
    endtask

    task automatic set_state(input logic [1:0] s);
        @(negedge clk) link_state = s;
        idle();
    endtask

    task automatic warm(input logic pol, output logic rq, output logic tm);
        @(negedge clk) begin warm_done = 1'b1; far_polled = pol; end
        @(negedge clk) warm_done = 1'b0;
        rq = det_req;
        tm = term_off;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        logic tm, rq;
        repeat (3) @(negedge clk);
        check("R11 det_req in reset", int'(det_req), 0);
        check("R11 term_off in reset", int'(term_off), 0);
        rst = 1'b0;
        idle();
        check("R11 det_req after reset", int'(det_req), 0);
        check("R11 term_off after reset", int'(term_off), 0);

        // R1 / R2 / R3 table walk
        for (int i = 0; i < 8; i++) begin
            set_state(2'd0);
            if (VEC[i][11:10] == 2'd1) norm_code = VEC[i][9:8];
            else                        lp_code   = VEC[i][9:8];
            set_state(VEC[i][11:10]);
            measure(200, n, tm);
            check((VEC[i][11:10] == 2'd1) ? "R1 interval" : "R2 interval", n, int'(VEC[i][7:0]));
            measure(200, n, tm);
            check("R3 repeat interval", n, int'(VEC[i][7:0]));
        end

        // R4: partial count discarded on state change
        set_state(2'd0);
        norm_code = 2'd1;
        set_state(2'd1);
        for (int k = 0; k < 3; k++) tick(rq, tm);
        set_state(2'd0);
        set_state(2'd1);
        measure(200, n, tm);
        check("R4 restart after change", n, 6);

        // R5: idle states never request
        set_state(2'd0);
        measure(170, n, tm);
        check("R5 no request in state 0", n, 0);
        set_state(2'd3);
        measure(170, n, tm);
        check("R5 no request in state 3", n, 0);

        // R6: U2/U3 detection disabled
        lp_code = 2'd0;
        lp_det_off = 1'b1;
        set_state(2'd2);
        measure(170, n, tm);
        check("R6 no request with U2/U3 disable", n, 0);
        lp_det_off = 1'b0;
        set_state(2'd0);

        // R7 / R8 warm reset
        warm_skip_en = 1'b0;
        warm(1'b1, rq, tm);
        check("R7 request after warm reset", int'(rq), 1);
        check("R9 term_off low when disabled", int'(tm), 0);
        warm_skip_en = 1'b1;
        warm(1'b0, rq, tm);
        check("R7 request when far end not polled", int'(rq), 1);
        warm(1'b1, rq, tm);
        check("R8 request skipped", int'(rq), 0);
        idle();
        check("R8 still no request", int'(det_req), 0);
        warm_skip_en = 1'b0;

        // R9: termination dropped with warm-reset request
        term_drop_en = 1'b1;
        warm(1'b0, rq, tm);
        check("R9 warm request", int'(rq), 1);
        check("R9 term_off with warm request", int'(tm), 1);

        // R10: first timed request in disconnected drops termination
        norm_code = 2'd0;
        set_state(2'd1);
        measure(200, n, tm);
        check("R10 first interval", n, 4);
        check("R10 term_off on first request", int'(tm), 1);
        measure(200, n, tm);
        check("R10 second interval", n, 4);
        check("R10 term_off low on later request", int'(tm), 0);

        // R10: U2/U3 entry is not a disconnect entry
        lp_code = 2'd0;
        set_state(2'd2);
        measure(200, n, tm);
        check("R10 U2/U3 interval", n, 48);
        check("R10 no term_off in U2/U3", int'(tm), 0);

        // R9: disable keeps term_off low on first disconnect request
        term_drop_en = 1'b0;
        set_state(2'd0);
        set_state(2'd1);
        measure(200, n, tm);
        check("R9 term_off stays low when disabled", int'(tm), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule